// File: doc/BRIEF.md
# Slot-Based Data Bus Scheduler

This block sits on the processor side of a memory channel whose memory stack runs its own array timing. It does not emit row, column or precharge commands. It treats the channel's data bus as a train of equal-length slots, each long enough to move one cache line. When a request arrives, it reserves a return slot far enough ahead to cover the memory latency. That latency is the address transfer time plus the bank access time plus the data bus delay, and it is held as one number. The block also reserves a spare slot for the same request, for use if the primary slot turns out to be unusable.

A free-running cycle counter starts at zero when reset is released and acts as the time base. Slot n covers cycles n*S to n*S+S-1. Occupancy is kept in a circular bitmap with one bit per slot, indexed by the slot number modulo the window size. A bit is cleared when its slot has gone by. The bit of a spare slot can also be cleared early through a release input, once the primary transfer has finished. For each accepted request, the response reports the primary slot, the spare slot and the cycle in which the request must be sent to the memory.

Top module: `slot_sched`

## Requirements
- R1: While `rstN` is low the block captures `cfgLatency` as the latency ML and marks every slot free. After reset `respValid` is 0, and later changes on `cfgLatency` have no effect.
- R2: Slot length is S = 2^SLOT_LOG2 cycles. The cycle counter reads 0 in the first cycle after reset, and slot n spans cycles n*S to n*S+S-1.
- R3: For a request granted in cycle t, the primary slot is the lowest-numbered free slot that is not below ceil((t+ML)/S).
- R4: The backup slot is the next free slot above the primary. Both lie within the window of WIN slots, from the current slot up to the current slot plus WIN-1.
- R5: `respIssue` equals primary*S - ML, and it is never earlier than the grant cycle t.
- R6: A request is granted on a clock edge where `reqValid` and `reqReady` are both 1. `respValid` is 1 in the following cycle, together with the granted `reqId` and `reqWrite`. In every other cycle `respValid` is 0.
- R7: If the window does not hold two free slots at or after the search start, `reqReady` is 0, no response follows and no slot is reserved. The requester keeps `reqValid` high, and the request is tried again in the next cycle.
- R8: A pulse on `relValid` clears the slot whose number modulo WIN is `relSlot`. A later request can then reserve that slot.
- R9: A reserved slot is never handed out again while it is inside the window. Once its last cycle has passed, its bit is free for the slot WIN positions later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cfgLatency | input | LW | Memory latency in cycles, sampled during reset |
| reqValid | input | 1 | Request present |
| reqId | input | IDW | Request tag |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqReady | output | 1 | Two free slots are available; the request is granted on this edge |
| relValid | input | 1 | Free a spare slot |
| relSlot | input | WIN_LOG2 | Slot number modulo WIN to free |
| respValid | output | 1 | Grant result valid |
| respId | output | IDW | Tag of the granted request |
| respWrite | output | 1 | Direction of the granted request |
| respSlot | output | TW-SLOT_LOG2 | Absolute primary slot number |
| respBackup | output | TW-SLOT_LOG2 | Absolute backup slot number |
| respIssue | output | TW | Cycle in which to send the request to memory |

## Verification
`reqReady` is combinational from the occupancy and the current cycle. The bench therefore drives a request half a cycle before an edge and reads the ready flag in that same half-cycle. The grant result is registered once, so the bench checks it at the falling edge right after the granting edge. A release takes effect on the first edge after it is driven and is seen through the next grant. The bench's slot model works from its own count of edges since reset, so each expected slot and issue cycle comes from the cycle in which the grant edge occurs.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic reserve;   // commit primary and backup slot bits
    logic release_;  // clear a spare slot bit
  } strobe_t;
endpackage

// File: rtl/slot_sched_dp.sv
module slot_sched_dp
  import slot_sched_pkg::*;
#(
  parameter int TW        = 20,
  parameter int SLOT_LOG2 = 2,
  parameter int LW        = 8,
  parameter int WIN_LOG2  = 6,
  localparam int SW       = TW - SLOT_LOG2,
  localparam int WIN      = 1 << WIN_LOG2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LW-1:0]       cfgLatency,
  input  strobe_t             strb,
  input  logic [WIN_LOG2-1:0] relSlot,
  output logic                pairFound,
  output logic [SW-1:0]       primSlot,
  output logic [SW-1:0]       backSlot,
  output logic [TW-1:0]       issueCyc
);
  logic [TW-1:0]       cyc;
  logic [LW-1:0]       lat;
  logic [WIN-1:0]      busy, busyNext;
  logic [SW-1:0]       curSlot;
  logic [WIN_LOG2-1:0] curIdx;
  logic [TW:0]         searchEnd;
  logic [SW:0]         startSlot, startOff;
  logic [WIN-1:0]      cand, candB;
  logic [WIN_LOG2-1:0] firstOff, secondOff;
  logic                endOfSlot;

  // Time base and latency capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cyc <= '0;
      lat <= cfgLatency;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  assign curSlot   = cyc[TW-1:SLOT_LOG2];
  assign curIdx    = curSlot[WIN_LOG2-1:0];
  assign endOfSlot = (cyc[SLOT_LOG2-1:0] == {SLOT_LOG2{1'b1}});

  // Earliest slot whose start is at or after now + latency
  assign searchEnd = {1'b0, cyc} + (TW+1)'(lat) + (TW+1)'((1 << SLOT_LOG2) - 1);
  assign startSlot = searchEnd[TW:SLOT_LOG2];
  assign startOff  = startSlot - {1'b0, curSlot};

  // Candidate vector, position o = slot curSlot+o
  for (genvar o = 0; o < WIN; o++) begin : g_cand
    assign cand[o] = !busy[WIN_LOG2'(curIdx + WIN_LOG2'(o))] &&
                     (startOff <= (SW+1)'(o));
  end

  always_comb begin
    firstOff = '0;
    for (int o = WIN - 1; o >= 0; o--) begin
      if (cand[o]) firstOff = WIN_LOG2'(o);
    end
  end

  assign candB = cand & ~(WIN'(1) << firstOff);

  always_comb begin
    secondOff = '0;
    for (int o = WIN - 1; o >= 0; o--) begin
      if (candB[o]) secondOff = WIN_LOG2'(o);
    end
  end

  assign pairFound = (|cand) && (|candB);
  assign primSlot  = curSlot + SW'(firstOff);
  assign backSlot  = curSlot + SW'(secondOff);
  assign issueCyc  = {primSlot, {SLOT_LOG2{1'b0}}} - TW'(lat);

  // Occupancy update: release, then reserve, then passing slot clears last
  always_comb begin
    busyNext = busy;
    if (strb.release_) busyNext[relSlot] = 1'b0;
    if (strb.reserve) begin
      busyNext[primSlot[WIN_LOG2-1:0]] = 1'b1;
      busyNext[backSlot[WIN_LOG2-1:0]] = 1'b1;
    end
    if (endOfSlot) busyNext[curIdx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busy <= '0;
    else       busy <= busyNext;
  end
endmodule

// File: rtl/slot_sched_ctrl.sv
module slot_sched_ctrl
  import slot_sched_pkg::*;
#(
  parameter int TW  = 20,
  parameter int SW  = 18,
  parameter int IDW = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  input  logic [IDW-1:0] reqId,
  input  logic           reqWrite,
  input  logic           relValid,
  input  logic           pairFound,
  input  logic [SW-1:0]  primSlot,
  input  logic [SW-1:0]  backSlot,
  input  logic [TW-1:0]  issueCyc,
  output strobe_t        strb,
  output logic           reqReady,
  output logic           respValid,
  output logic [IDW-1:0] respId,
  output logic           respWrite,
  output logic [SW-1:0]  respSlot,
  output logic [SW-1:0]  respBackup,
  output logic [TW-1:0]  respIssue
);
  logic grant;

  assign reqReady     = pairFound;
  assign grant        = reqValid && pairFound;
  assign strb.reserve  = grant;
  assign strb.release_ = relValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respId     <= '0;
      respWrite  <= 1'b0;
      respSlot   <= '0;
      respBackup <= '0;
      respIssue  <= '0;
    end else begin
      respValid <= grant;
      if (grant) begin
        respId     <= reqId;
        respWrite  <= reqWrite;
        respSlot   <= primSlot;
        respBackup <= backSlot;
        respIssue  <= issueCyc;
      end
    end
  end
endmodule

// File: rtl/slot_sched.sv
module slot_sched
  import slot_sched_pkg::*;
#(
  parameter int TW        = 20,
  parameter int SLOT_LOG2 = 2,
  parameter int LW        = 8,
  parameter int WIN_LOG2  = 6,
  parameter int IDW       = 4,
  localparam int SW       = TW - SLOT_LOG2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LW-1:0]       cfgLatency,
  input  logic                reqValid,
  input  logic [IDW-1:0]      reqId,
  input  logic                reqWrite,
  output logic                reqReady,
  input  logic                relValid,
  input  logic [WIN_LOG2-1:0] relSlot,
  output logic                respValid,
  output logic [IDW-1:0]      respId,
  output logic                respWrite,
  output logic [SW-1:0]       respSlot,
  output logic [SW-1:0]       respBackup,
  output logic [TW-1:0]       respIssue
);
  strobe_t       strb;
  logic          pairFound;
  logic [SW-1:0] primSlot, backSlot;
  logic [TW-1:0] issueCyc;

  slot_sched_dp #(
    .TW(TW), .SLOT_LOG2(SLOT_LOG2), .LW(LW), .WIN_LOG2(WIN_LOG2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgLatency(cfgLatency), .strb(strb),
    .relSlot(relSlot), .pairFound(pairFound), .primSlot(primSlot),
    .backSlot(backSlot), .issueCyc(issueCyc)
  );

  slot_sched_ctrl #(.TW(TW), .SW(SW), .IDW(IDW)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqId(reqId),
    .reqWrite(reqWrite), .relValid(relValid), .pairFound(pairFound),
    .primSlot(primSlot), .backSlot(backSlot), .issueCyc(issueCyc),
    .strb(strb), .reqReady(reqReady), .respValid(respValid),
    .respId(respId), .respWrite(respWrite), .respSlot(respSlot),
    .respBackup(respBackup), .respIssue(respIssue)
  );
endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk #(
  parameter int TW       = 20,
  parameter int SW       = 18,
  parameter int WIN_LOG2 = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic          respValid,
  input logic [SW-1:0] respSlot,
  input logic [SW-1:0] respBackup,
  input logic [TW-1:0] respIssue
);
  logic [TW:0] cycSeen;

  always_ff @(posedge clk) begin
    if (!rstN) cycSeen <= '0;
    else       cycSeen <= cycSeen + 1'b1;
  end

  a_r6_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> respValid);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !respValid);

  a_r7_hold_no_resp: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> !respValid);

  a_r4_backup_after: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (respBackup > respSlot));

  a_r4_in_window: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ((respBackup - respSlot) < SW'(1 << WIN_LOG2)));

  a_r5_issue_not_past: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (({1'b0, respIssue} + 1'b1) >= cycSeen));
endmodule

bind slot_sched slot_sched_chk #(.TW(TW), .SW(SW), .WIN_LOG2(WIN_LOG2)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .respValid(respValid), .respSlot(respSlot), .respBackup(respBackup),
  .respIssue(respIssue)
);

// File: tb/sim_slot_sched.sv
module sim_slot_sched;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 20, SLOT_LOG2 = 2, LW = 8, WIN_LOG2 = 6, IDW = 4;
  localparam int SW = TW - SLOT_LOG2;
  localparam int S = 1 << SLOT_LOG2;
  localparam int WIN = 1 << WIN_LOG2;
  localparam int ML = 10;
  localparam int NV = 12;
  // {gap cycles[7:0], id[3:0], write}
  localparam logic [12:0] VEC [NV] = '{
    {8'd0, 4'd1, 1'b0}, {8'd0, 4'd2, 1'b1}, {8'd1, 4'd3, 1'b0},
    {8'd2, 4'd4, 1'b1}, {8'd3, 4'd5, 1'b0}, {8'd0, 4'd6, 1'b0},
    {8'd5, 4'd7, 1'b1}, {8'd0, 4'd8, 1'b1}, {8'd7, 4'd9, 1'b0},
    {8'd1, 4'd10, 1'b1}, {8'd0, 4'd11, 1'b0}, {8'd4, 4'd12, 1'b1}
  };

  logic clk = 0, rstN = 0;
  logic [LW-1:0] cfgLatency = LW'(ML);
  logic reqValid = 0, reqWrite = 0, relValid = 0;
  logic [IDW-1:0] reqId = '0;
  logic [WIN_LOG2-1:0] relSlot = '0;
  logic reqReady, respValid, respWrite;
  logic [IDW-1:0] respId;
  logic [SW-1:0] respSlot, respBackup;
  logic [TW-1:0] respIssue;

  int checks = 0, errors = 0;
  int edgeCnt = 0;
  bit modelBusy [0:8191];
  int lastP, lastB, lastOk;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rstN) edgeCnt <= edgeCnt + 1;

  slot_sched #(.TW(TW), .SLOT_LOG2(SLOT_LOG2), .LW(LW), .WIN_LOG2(WIN_LOG2),
               .IDW(IDW)) u0 (
    .clk(clk), .rstN(rstN), .cfgLatency(cfgLatency), .reqValid(reqValid),
    .reqId(reqId), .reqWrite(reqWrite), .reqReady(reqReady),
    .relValid(relValid), .relSlot(relSlot), .respValid(respValid),
    .respId(respId), .respWrite(respWrite), .respSlot(respSlot),
    .respBackup(respBackup), .respIssue(respIssue)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Model of R3/R4/R7/R9: search [start, cur+WIN-1] in own slot set
  task automatic modelSearch(output bit ok, output int p, output int b);
    int cur, st;
    cur = edgeCnt / S;
    st  = (edgeCnt + ML + S - 1) / S;
    p = -1; b = -1;
    for (int s = st; s <= cur + WIN - 1; s++) begin
      if (!modelBusy[s]) begin
        if (p < 0) p = s;
        else if (b < 0) b = s;
      end
    end
    ok = (b >= 0);
  endtask

  // Entered and left at a falling edge
  task automatic doReq(input logic [IDW-1:0] id, input logic wr);
    bit ok; int p, b, t;
    modelSearch(ok, p, b);
    t = edgeCnt;
    reqValid = 1; reqId = id; reqWrite = wr;
    #1;
    chk(reqReady == ok, ok ? "R3" : "R7", "reqReady", reqReady, ok);
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    chk(respValid == ok, ok ? "R6" : "R7", "respValid", respValid, ok);
    if (ok && respValid) begin
      chk(respSlot == SW'(p), "R3", "primary slot", respSlot, p);
      chk(respBackup == SW'(b), "R4", "backup slot", respBackup, b);
      chk(respIssue == TW'(p * S - ML), "R5", "issue cycle", respIssue, p * S - ML);
      chk(int'(respIssue) >= t, "R5", "issue not before grant", respIssue, t);
      chk(respId == id && respWrite == wr, "R6", "id/write", {respId, respWrite}, {id, wr});
      modelBusy[p] = 1; modelBusy[b] = 1;
    end
    lastOk = ok; lastP = p; lastB = b;
  endtask

  task automatic doRelease(input int slot);
    relValid = 1; relSlot = WIN_LOG2'(slot);
    @(posedge clk);
    @(negedge clk);
    relValid = 0;
    modelBusy[slot] = 0;
  endtask

  initial begin
    for (int s = 0; s < 8192; s++) modelBusy[s] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    cfgLatency = 8'd33;  // R1: must be ignored after reset
    #1;
    chk(respValid == 0, "R1", "respValid after reset", respValid, 0);
    chk(reqReady == 1, "R1", "all slots free after reset", reqReady, 1);
    @(negedge clk);

    // R2/R3: first request in cycle 1 -> start slot ceil(11/4)=3, issue 2
    doReq(4'd0, 1'b0);
    chk(lastP == 3 && respSlot == 3, "R2", "first slot from time base", respSlot, 3);
    chk(respIssue == 2, "R1", "latency captured at reset", respIssue, 2);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      repeat (int'(VEC[v][12:5])) @(negedge clk);
      doReq(VEC[v][4:1], VEC[v][0]);
    end

    // R7: saturate the window with back-to-back requests
    begin
      int refused = 0;
      for (int k = 0; k < 60; k++) begin
        doReq(IDW'(k), k[0]);
        if (!lastOk) refused++;
      end
      chk(refused > 0, "R7", "window saturation seen", refused, 1);
    end

    // R8: release the most recent backup slot; it must come back as primary
    begin
      int held = 0, relTarget = 0;
      bit granted = 0;
      for (int s = 8191; s >= 0; s--) if (modelBusy[s] && relTarget == 0) relTarget = s;
      doRelease(relTarget);
      for (int k = 0; k < 20 && !granted; k++) begin
        doReq(4'hE, 1'b1);
        if (lastOk) granted = 1; else held++;
      end
      chk(granted, "R8", "request granted after release", granted, 1);
      chk(respSlot == SW'(relTarget), "R8", "released slot reused", respSlot, relTarget);
    end

    // R9: idle long enough for every reserved slot to pass
    repeat (WIN * S + 16) @(negedge clk);
    begin
      int st;
      st = (edgeCnt + ML + S - 1) / S;
      doReq(4'h5, 1'b0);
      chk(respSlot == SW'(st), "R9", "passed slots free again", respSlot, st);
      chk(respBackup == SW'(st + 1), "R9", "backup adjacent", respBackup, st + 1);
    end
    // R9: the same slots are not handed out twice in the window
    doReq(4'h6, 1'b1);
    chk(respSlot > SW'(lastP - 0) - 1 && respSlot != respBackup, "R9", "no double booking",
        respSlot, lastP);
    repeat (3) @(negedge clk);
    doReq(4'h7, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule